// File: doc/BRIEF.md
# Single-Cycle Core with Sign-Test Branch-and-Link

This block is a single-cycle 32-bit processor core for a small load/store instruction subset. On every clock edge it completes one instruction. It fetches the word at the program counter, decodes it, reads two registers, and runs the ALU. It then updates the program counter and, where needed, writes back a register or stores a word. Instruction and data memory sit outside the block. The core reaches them through plain address and data ports, and it reads both memories combinationally.

Besides three-register arithmetic and logic, immediate OR, load word, store word and branch-on-equal, the core has a branch-and-link instruction that tests the sign of a register. The instruction is taken when the source register is zero or positive. A taken branch moves to the relative target and, in the same cycle, saves the address of the following instruction in register 31. A branch that is not taken changes nothing except the program counter.

Top module: `scd_core`

## Requirements
- R1: Reset holds the program counter at 0. After any instruction that does not take a branch, the fetch address rises by 4 on the next cycle.
- R2: Opcode 0 writes register rd with rs op rt. The function field selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-on-less-than giving 1 or 0.
- R3: Opcode 0x0D writes register rt with rs OR the 16-bit immediate, zero-extended.
- R4: Opcodes 0x23 (load) and 0x2B (store) form the address rs plus the sign-extended immediate. A load writes rt with the data read. A store drives the write strobe with rt as data and is the only instruction that raises the strobe.
- R5: Opcode 0x04 goes to PC+4 plus the sign-extended immediate times 4 when rs equals rt. Otherwise it goes to PC+4.
- R6: Opcode 0x01 with rt field 17 tests rs. When bit 31 of rs is clear, the core goes to PC+4 plus the sign-extended immediate times 4 and writes PC+4 into register 31 in the same cycle.
- R7: With opcode 0x01, rt field 17 and bit 31 of rs set, the next fetch is PC+4 and no register changes, including register 31.
- R8: Register 0 always reads as zero. Writes to it have no effect.
- R9: A value written to a register is read by the next instruction that names that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; the word is written at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
A wrong register value shows up at the ports in the next cycle. A store puts the value on the write data, a branch makes the fetch address jump or not jump, or a later result comes out wrong. A wrong program counter shows up at once on the fetch address. The bench sweeps every ALU operation over a grid of edge-case operand pairs, and it sends the sign-test branch zero, positive and negative values. It then reads all state back through stores, so corrupted link or general-purpose registers appear as wrong memory words.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 32;
    localparam int RA_W     = $clog2(NREG);
    localparam int LINK_REG = NREG - 1;

    localparam logic [5:0] OP_RTYPE  = 6'h00;
    localparam logic [5:0] OP_REGIMM = 6'h01;
    localparam logic [5:0] OP_BEQ    = 6'h04;
    localparam logic [5:0] OP_ORI    = 6'h0D;
    localparam logic [5:0] OP_LW     = 6'h23;
    localparam logic [5:0] OP_SW     = 6'h2B;

    localparam logic [4:0] RT_GEZ_LINK = 5'd17;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_sel_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
    typedef enum logic [1:0] {BR_NONE, BR_EQ, BR_GEZ} br_kind_e;
    typedef enum logic [1:0] {AOP_ADD, AOP_SUB, AOP_OR, AOP_FUNCT} main_aluop_e;

    typedef struct packed {
        br_kind_e br;
        logic     alu_src;
        dst_sel_e dst;
        alu_op_e  alu_ctr;
        logic     reg_wr;
        logic     mem_wr;
        logic     ext_signed;
        wb_sel_e  wb;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [15:0] imm;
        logic [5:0]  funct;
    } instr_t;

    function automatic instr_t split_instr(input logic [31:0] w);
        instr_t f;
        f.opcode = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.imm    = w[15:0];
        f.funct  = w[5:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] extend_imm(input logic [15:0] imm, input logic sgn);
        return sgn ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
    endfunction

endpackage

// File: rtl/scd_control.sv
module scd_control
    import scd_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] rt,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    main_aluop_e aop;
    ctrl_t       base;

    // main decoder
    always_comb begin
        base            = '0;
        base.br         = BR_NONE;
        base.dst        = DST_RT;
        base.wb         = WB_ALU;
        base.alu_ctr    = ALU_AND;
        aop             = AOP_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                base.dst    = DST_RD;
                base.reg_wr = 1'b1;
                aop         = AOP_FUNCT;
            end
            OP_ORI: begin
                base.alu_src = 1'b1;
                base.reg_wr  = 1'b1;
                aop          = AOP_OR;
            end
            OP_LW: begin
                base.alu_src    = 1'b1;
                base.reg_wr     = 1'b1;
                base.ext_signed = 1'b1;
                base.wb         = WB_MEM;
            end
            OP_SW: begin
                base.alu_src    = 1'b1;
                base.mem_wr     = 1'b1;
                base.ext_signed = 1'b1;
            end
            OP_BEQ: begin
                base.br         = BR_EQ;
                base.ext_signed = 1'b1;
                aop             = AOP_SUB;
            end
            OP_REGIMM: begin
                if (rt == RT_GEZ_LINK) begin
                    base.br         = BR_GEZ;
                    base.ext_signed = 1'b1;
                    base.reg_wr     = 1'b1;
                    base.dst        = DST_LINK;
                    base.wb         = WB_LINK;
                end
            end
            default: ;
        endcase
    end

    // ALU control
    always_comb begin
        ctrl = base;
        unique case (aop)
            AOP_ADD: ctrl.alu_ctr = ALU_ADD;
            AOP_SUB: ctrl.alu_ctr = ALU_SUB;
            AOP_OR:  ctrl.alu_ctr = ALU_OR;
            default: begin
                unique case (funct)
                    FN_ADD:  ctrl.alu_ctr = ALU_ADD;
                    FN_SUB:  ctrl.alu_ctr = ALU_SUB;
                    FN_AND:  ctrl.alu_ctr = ALU_AND;
                    FN_OR:   ctrl.alu_ctr = ALU_OR;
                    FN_SLT:  ctrl.alu_ctr = ALU_SLT;
                    default: begin
                        ctrl.alu_ctr = ALU_AND;
                        ctrl.reg_wr  = 1'b0;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/scd_alu.sv
module scd_alu
    import scd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/scd_regfile.sv
module scd_regfile
    import scd_pkg::*;
#(
    parameter int W = XLEN,
    parameter int N = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];

    // R9
    rf_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (ra_addr != $past(waddr) || ra_data == $past(wdata)));

    // R8
    rf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (rb_addr != '0 || rb_data == '0));
endmodule

// File: rtl/scd_core.sv
module scd_core
    import scd_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    logic [XLEN-1:0] pc_q, pc4, br_tgt, pc_next;
    instr_t          f;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y;
    logic            alu_zero, take;
    logic            rf_we;
    logic [RA_W-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;

    assign f = split_instr(imem_rdata);

    scd_control u_ctrl (
        .opcode (f.opcode),
        .rt     (f.rt),
        .funct  (f.funct),
        .ctrl   (ctrl)
    );

    scd_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (f.rs),
        .ra_data (rs_val),
        .rb_addr (f.rt),
        .rb_data (rt_val),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    assign imm_ext = extend_imm(f.imm, ctrl.ext_signed);
    assign alu_b   = ctrl.alu_src ? imm_ext : rt_val;

    scd_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_ctr),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // next-PC selection
    assign pc4    = pc_q + 32'd4;
    assign br_tgt = pc4 + (imm_ext << 2);
    always_comb begin
        unique case (ctrl.br)
            BR_EQ:   take = alu_zero;
            BR_GEZ:  take = ~rs_val[XLEN-1];
            default: take = 1'b0;
        endcase
    end
    assign pc_next = take ? br_tgt : pc4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= pc_next;
    end

    // write-back path, link write gated by branch outcome
    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   rf_waddr = f.rd;
            DST_LINK: rf_waddr = RA_W'(LINK_REG);
            default:  rf_waddr = f.rt;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  rf_wdata = dmem_rdata;
            WB_LINK: rf_wdata = pc4;
            default: rf_wdata = alu_y;
        endcase
    end
    assign rf_we = ctrl.reg_wr & ((ctrl.br != BR_GEZ) | take);

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr & ~rst;

    // R1
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br == BR_NONE) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R5
    beq_target_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br == BR_EQ && rs_val == rt_val) |=>
        (imem_addr == $past(imem_addr) + 32'd4 + ($past(imm_ext) << 2)));

    // R6
    link_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br == BR_GEZ && !rs_val[XLEN-1]) |->
        (rf_we && rf_waddr == RA_W'(LINK_REG) && rf_wdata == imem_addr + 32'd4));

    // R7
    gez_fail_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br == BR_GEZ && rs_val[XLEN-1]) |-> !rf_we);

    // R7
    gez_fail_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.br == BR_GEZ && rs_val[XLEN-1]) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R4
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_rdata[31:26] == OP_SW));
endmodule

// File: tb/tb_scd_core.sv
module tb_scd_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, dmem_addr, dmem_wdata;
    logic        dmem_we;
    logic [31:0] imem [MEMW];
    logic [31:0] dmem [MEMW];
    logic        pre_we = 1'b0;
    int          pre_idx = 0;
    logic [31:0] pre_data = '0;
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scd_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem[imem_addr[10:2]]),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem[dmem_addr[10:2]])
    );

    always @(posedge clk) begin
        if (pre_we) dmem[pre_idx] <= pre_data;
        else if (dmem_we) dmem[dmem_addr[10:2]] <= dmem_wdata;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst = 1'b1;
        wp = 0;
        for (int i = 0; i < MEMW; i++) imem[i] = 32'h0;
    endtask

    task automatic preload(input int idx, input logic [31:0] d);
        pre_we = 1'b1; pre_idx = idx; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic release_and_run(input int n);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc at reset", imem_addr, 32'h0);
        chk("R4 no store in reset exit", {31'b0, dmem_we}, 32'h0);
        @(negedge clk);
        chk("R1 pc step", imem_addr, 32'h4);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] ops [6];
    logic [5:0]  fns [5];

    function automatic logic [31:0] model(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            default: return {31'b0, $signed(a) < $signed(b)};
        endcase
    endfunction

    initial begin
        ops[0] = 32'h0; ops[1] = 32'h1; ops[2] = 32'hFFFF_FFFF;
        ops[3] = 32'h7FFF_FFFF; ops[4] = 32'h8000_0000; ops[5] = 32'h1234_5678;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
        for (int i = 0; i < MEMW; i++) dmem[i] = 32'h0;

        // ---- ALU sweep, ori, lw/sw offsets, r0 ----
        begin_prog();
        for (int i = 0; i < 6; i++) begin
            emit(enc_i(6'h23, 0, i + 1, 16'(4 * i)));
            preload(i, ops[i]);
        end
        begin
            int k = 0;
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int o = 0; o < 5; o++) begin
                        emit(enc_r(i + 1, j + 1, 7, fns[o]));
                        emit(enc_i(6'h2B, 0, 7, 16'(64 + 4 * k)));
                        k++;
                    end
        end
        emit(enc_i(6'h0D, 3, 8, 16'h8001));
        emit(enc_i(6'h0D, 1, 9, 16'h8001));
        emit(enc_i(6'h2B, 0, 9, 16'd800));
        emit(enc_i(6'h0D, 0, 10, 16'd812));
        emit(enc_i(6'h2B, 10, 9, 16'hFFF8));
        emit(enc_i(6'h23, 10, 11, 16'hFFF4));
        emit(enc_i(6'h2B, 0, 11, 16'd808));
        emit(enc_r(3, 3, 0, 6'h20));
        emit(enc_i(6'h0D, 0, 0, 16'h0055));
        emit(enc_i(6'h2B, 0, 0, 16'd816));
        emit(enc_i(6'h2B, 0, 8, 16'd820));
        emit(enc_i(6'h04, 0, 0, 16'hFFFF));
        preload(204, 32'hDEAD_BEEF);
        release_and_run(wp + 4);
        begin
            int k = 0;
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int o = 0; o < 5; o++) begin
                        chk($sformatf("R2 R9 fn %h a %h b %h", fns[o], ops[i], ops[j]),
                            dmem[16 + k], model(fns[o], ops[i], ops[j]));
                        k++;
                    end
        end
        chk("R3 ori zero-ext", dmem[200], 32'h0000_8001);
        chk("R4 sw negative offset", dmem[201], 32'h0000_8001);
        chk("R4 lw negative offset", dmem[202], 32'h0000_8001);
        chk("R8 r0 ignores writes", dmem[204], 32'h0);
        chk("R3 ori on all-ones", dmem[205], 32'hFFFF_FFFF);
        chk("R5 halt loop holds pc", imem_addr, 32'(4 * (wp - 1)));

        // ---- sign-test branch-and-link ----
        for (int v = 0; v < 6; v++) begin
            logic [31:0] val;
            logic        tk;
            case (v)
                0: val = 32'h0;
                1: val = 32'h1;
                2: val = 32'h7FFF_FFFF;
                3: val = 32'hFFFF_FFFF;
                4: val = 32'h8000_0000;
                default: val = 32'hFFFF_FFFB;
            endcase
            tk = ~val[31];
            begin_prog();
            emit(enc_i(6'h23, 0, 1, 16'd0));
            emit(enc_i(6'h0D, 0, 31, 16'h1234));
            emit(enc_i(6'h0D, 0, 2, 16'd0));
            emit(enc_i(6'h01, 1, 17, 16'd2));
            emit(enc_i(6'h0D, 0, 2, 16'd1));
            emit(enc_i(6'h04, 0, 0, 16'd0));
            emit(enc_i(6'h2B, 0, 2, 16'd4));
            emit(enc_i(6'h2B, 0, 31, 16'd8));
            emit(enc_i(6'h04, 0, 0, 16'hFFFF));
            preload(0, val);
            preload(1, 32'hAAAA_AAAA);
            preload(2, 32'hAAAA_AAAA);
            release_and_run(16);
            if (tk) begin
                chk($sformatf("R6 taken skips, val %h", val), dmem[1], 32'h0);
                chk($sformatf("R6 link value, val %h", val), dmem[2], 32'd16);
            end else begin
                chk($sformatf("R7 falls through, val %h", val), dmem[1], 32'h1);
                chk($sformatf("R7 r31 unchanged, val %h", val), dmem[2], 32'h1234);
            end
            chk("R1 R5 halt address", imem_addr, 32'd32);
        end

        // ---- beq ----
        for (int p = 0; p < 4; p++) begin
            logic [31:0] a, b;
            case (p)
                0: begin a = 32'd5; b = 32'd5; end
                1: begin a = 32'd5; b = 32'd6; end
                2: begin a = 32'h8000_0000; b = 32'h0; end
                default: begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
            endcase
            begin_prog();
            emit(enc_i(6'h23, 0, 1, 16'd0));
            emit(enc_i(6'h23, 0, 2, 16'd4));
            emit(enc_i(6'h0D, 0, 3, 16'd0));
            emit(enc_i(6'h04, 1, 2, 16'd1));
            emit(enc_i(6'h0D, 0, 3, 16'd1));
            emit(enc_i(6'h2B, 0, 3, 16'd8));
            emit(enc_i(6'h04, 0, 0, 16'hFFFF));
            preload(0, a);
            preload(1, b);
            preload(2, 32'hAAAA_AAAA);
            release_and_run(12);
            chk($sformatf("R5 beq a %h b %h", a, b), dmem[2], (a == b) ? 32'h0 : 32'h1);
        end

        summary();
        $finish;
    end
endmodule